// File: doc/BRIEF.md
# Memory-Mapped GPIO Data Port with Atomic Bit Updates

This block is the data side of a general-purpose I/O port with 32 pins. A simple register bus (one write strobe, one read strobe, a byte offset and a data word) reaches an output latch, a direction register and a synchronized view of the input pads. The block drives an output-enable vector and an output-value vector toward the pad ring and takes the raw pad levels back. Pad drivers, pin multiplexing and clock gating live elsewhere.

Software can change single output bits without reading the latch first. Three write-only alias offsets set, clear or invert exactly the bits written as one, so two agents that own different pins never overwrite each other's bits. The input offset returns, for each pin, the output latch when the pin is an output and the synchronized pad level when it is an input.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, the output latch and the direction register are zero, so `pad_oe` and `pad_out` are all zero, and `rdata` is zero.
- R2: A write to offset 0x00 loads the output latch with `wdata`; `pad_out` shows it after the write edge, and a read of 0x00 returns it.
- R3: A write to offset 0x04 drives high each output bit written as 1; bits written as 0 keep their value.
- R4: A write to offset 0x08 drives low each output bit written as 1; bits written as 0 keep their value.
- R5: A write to offset 0x0C inverts each output bit written as 1; bits written as 0 keep their value.
- R6: Reads of offsets 0x04, 0x08 and 0x0C return zero.
- R7: A write to offset 0x14 loads the direction register, where bit n = 1 makes pin n an output; `pad_oe` follows it after the write edge and a read of 0x14 returns it.
- R8: A read of offset 0x10 returns, for bit n, the output latch bit when direction bit n is 1, otherwise the pad level of pin n after a two-flop synchronizer: a pad change made before clock edge k is seen by a read whose strobe is sampled at edge k+2, and not by one sampled at edge k+1.
- R9: `rdata` is registered: it takes the read value at the edge that samples `rd_en` and holds that value while `rd_en` is low.
- R10: Writes to offset 0x10 or to any unmapped offset change neither the output latch nor the direction register, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| addr | input | ADDR_W (5) | Byte offset of the register |
| wdata | input | PINS (32) | Write data, bit n for pin n |
| rdata | output | PINS (32) | Registered read data |
| pad_in | input | PINS (32) | Raw pad levels, asynchronous |
| pad_oe | output | PINS (32) | Output enable per pin (direction register) |
| pad_out | output | PINS (32) | Output value per pin (output latch) |

## Verification
A write takes effect at the edge that samples `wr_en`, so `pad_out` and `pad_oe` are checked half a cycle later, and a read returns its word at the edge that samples `rd_en`, so `rdata` is checked on the following falling edge. The input path adds two register stages; the bench changes a pad, then issues one read one edge too early (expecting the old level) and one read exactly two edges after the change (expecting the new level). All stimulus is applied on falling edges so no check depends on process order at the rising edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned OFS_DATA = 32'h00;
  localparam int unsigned OFS_SET  = 32'h04;
  localparam int unsigned OFS_CLR  = 32'h08;
  localparam int unsigned OFS_TOG  = 32'h0C;
  localparam int unsigned OFS_IN   = 32'h10;
  localparam int unsigned OFS_DIR  = 32'h14;

  typedef enum logic [2:0] {
    ACC_DATA,
    ACC_SET,
    ACC_CLR,
    ACC_TOG,
    ACC_IN,
    ACC_DIR,
    ACC_NONE
  } acc_e;

  function automatic acc_e decode_ofs(input logic [31:0] ofs);
    acc_e r;
    case (ofs)
      OFS_DATA: r = ACC_DATA;
      OFS_SET:  r = ACC_SET;
      OFS_CLR:  r = ACC_CLR;
      OFS_TOG:  r = ACC_TOG;
      OFS_IN:   r = ACC_IN;
      OFS_DIR:  r = ACC_DIR;
      default:  r = ACC_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  acc_e             acc,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] dir_q
);

  logic [WIDTH-1:0] out_nxt;

  always_comb begin
    out_nxt = out_q;
    if (wr_en) begin
      case (acc)
        ACC_DATA: out_nxt = wdata;
        ACC_SET:  out_nxt = out_q | wdata;
        ACC_CLR:  out_nxt = out_q & ~wdata;
        ACC_TOG:  out_nxt = out_q ^ wdata;
        default:  out_nxt = out_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      out_q <= out_nxt;
      if (wr_en && acc == ACC_DIR) dir_q <= wdata;
    end
  end

endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  acc_e             acc,
  input  logic [WIDTH-1:0] out_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] in_q,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] rd_val;

  always_comb begin
    case (acc)
      ACC_DATA: rd_val = out_q;
      ACC_IN:   rd_val = (dir_q & out_q) | (~dir_q & in_q);
      ACC_DIR:  rd_val = dir_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS        = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_out
);

  acc_e            acc;
  logic [PINS-1:0] out_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] in_q;

  assign acc = decode_ofs(32'(addr));

  gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (in_q)
  );

  gpio_out_regs #(.WIDTH(PINS)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .acc   (acc),
    .wdata (wdata),
    .out_q (out_q),
    .dir_q (dir_q)
  );

  gpio_rd_path #(.WIDTH(PINS)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .acc   (acc),
    .out_q (out_q),
    .dir_q (dir_q),
    .in_q  (in_q),
    .rdata (rdata)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [PINS-1:0]   wdata,
  input logic [PINS-1:0]   rdata,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   pad_out
);

  logic [31:0] ofs;
  logic        wr_other;
  assign ofs      = 32'(addr);
  assign wr_other = ofs != OFS_DATA && ofs != OFS_SET && ofs != OFS_CLR &&
                    ofs != OFS_TOG && ofs != OFS_DIR;

  // R2
  wr_data_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ofs == OFS_DATA) |=> pad_out == $past(wdata));

  // R3
  wr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ofs == OFS_SET) |=> pad_out == ($past(pad_out) | $past(wdata)));

  // R4
  wr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ofs == OFS_CLR) |=> pad_out == ($past(pad_out) & ~$past(wdata)));

  // R5
  wr_tog_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ofs == OFS_TOG) |=> pad_out == ($past(pad_out) ^ $past(wdata)));

  // R6
  rd_alias_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (ofs == OFS_SET || ofs == OFS_CLR || ofs == OFS_TOG)) |=> rdata == '0);

  // R7
  wr_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ofs == OFS_DIR) |=> pad_oe == $past(wdata));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R10
  wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_other) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R10
  wr_dir_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ofs != OFS_DIR) |=> $stable(pad_oe));

endmodule

bind gpio_port gpio_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .pad_oe  (pad_oe),
  .pad_out (pad_out)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PINS   = 32;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [PINS-1:0]   wdata = '0;
  logic [PINS-1:0]   rdata;
  logic [PINS-1:0]   pad_in = '0;
  logic [PINS-1:0]   pad_oe;
  logic [PINS-1:0]   pad_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.PINS(PINS), .ADDR_W(ADDR_W)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pad_in  (pad_in),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );

  task automatic check(input string req, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [PINS-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [PINS-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    check("R1 rdata", rdata, '0);
  endtask

  task automatic t_data;
    logic [PINS-1:0] v;
    bus_write(5'h00, 32'hA5C3_0F81);
    check("R2 pad_out", pad_out, 32'hA5C3_0F81);
    bus_read(5'h00, v);
    check("R2 readback", v, 32'hA5C3_0F81);
  endtask

  task automatic t_alias;
    logic [PINS-1:0] v;
    bus_write(5'h00, 32'h0000_FFFF);
    bus_write(5'h04, 32'h00F0_00F0);
    check("R3 set", pad_out, 32'h00F0_FFFF);
    bus_write(5'h08, 32'h8000_0F0F);
    check("R4 clear", pad_out, 32'h00F0_F0F0);
    bus_write(5'h0C, 32'hFFFF_0000);
    check("R5 toggle", pad_out, 32'hFF0F_F0F0);
    bus_write(5'h0C, 32'h0000_0000);
    check("R5 toggle zero", pad_out, 32'hFF0F_F0F0);
    bus_read(5'h04, v); check("R6 set reads zero", v, '0);
    bus_read(5'h08, v); check("R6 clear reads zero", v, '0);
    bus_read(5'h0C, v); check("R6 toggle reads zero", v, '0);
  endtask

  task automatic t_dir;
    logic [PINS-1:0] v;
    bus_write(5'h14, 32'h0000_FF00);
    check("R7 pad_oe", pad_oe, 32'h0000_FF00);
    bus_read(5'h14, v);
    check("R7 readback", v, 32'h0000_FF00);
  endtask

  task automatic t_input;
    logic [PINS-1:0] v;
    // latch 0xFF0FF0F0, direction 0x0000FF00
    pad_in = 32'h1234_5678;
    @(negedge clk); @(negedge clk); @(negedge clk);
    bus_read(5'h10, v);
    check("R8 mixed", v, (32'h0000_FF00 & 32'hFF0F_F0F0) | (~32'h0000_FF00 & 32'h1234_5678));
    pad_in = 32'hFFFF_FFFF;
    bus_read(5'h10, v);
    check("R8 one edge early", v, 32'h1234_F078);
    pad_in = 32'h0000_0000;
    @(negedge clk);
    bus_read(5'h10, v);
    check("R8 two edges", v, 32'h0000_F000);
  endtask

  task automatic t_hold_ignore;
    logic [PINS-1:0] v;
    bus_read(5'h00, v);
    @(negedge clk); @(negedge clk);
    check("R9 hold", rdata, 32'hFF0F_F0F0);
    bus_write(5'h10, 32'hFFFF_FFFF);
    check("R10 input write pad_out", pad_out, 32'hFF0F_F0F0);
    check("R10 input write pad_oe", pad_oe, 32'h0000_FF00);
    bus_write(5'h18, 32'h0000_0001);
    bus_write(5'h1C, 32'hFFFF_FFFF);
    check("R10 unmapped pad_out", pad_out, 32'hFF0F_F0F0);
    check("R10 unmapped pad_oe", pad_oe, 32'h0000_FF00);
    bus_read(5'h18, v);
    check("R10 unmapped read", v, '0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_data();
    t_alias();
    t_dir();
    t_input();
    t_hold_ignore();
    done = 1'b1;
    report();
  end

endmodule